// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the byte-wide programming front end of an 8-input priority interrupt controller. The processor side reaches it through two locations selected by one address bit: a command location (address 0) and a data location (address 1). Each write is decoded as a setup word or an operating command. An internal sequencer walks the setup words in order and skips the optional third and fourth words according to two bits of the first word.

The block holds the interrupt mask, the vector base and the captured setup words. It also holds the selector that decides which status byte a read of the command location returns. The selected status byte is one of the request and in-service bytes, which a neighbouring status block supplies. End-of-interrupt commands become a one-cycle clear mask that the status block applies to its in-service register. Undecodable commands produce a one-cycle error pulse.

Top module: `pic_cmd_if`

## Requirements
- R1: After reset the sequencer waits for the first setup word, `ready` is 0, and `imr`, `vec_base`, `cfg_icw1`, `cfg_icw3` and `cfg_icw4` are all 0x00. The status selector is 2'b10, so a command-location read returns `irr_in`.
- R2: A command-location write with bit 4 set is taken as the first setup word in every state. It is stored in `cfg_icw1`, `ready` drops, and the next data write is taken as the vector base.
- R3: The data write that loads `vec_base` leads next to the third setup word when `cfg_icw1` bit 1 is 0. When bit 1 is 1, it leads to the fourth word if `cfg_icw1` bit 0 is 1, and otherwise straight to ready.
- R4: A data write in the third-word state loads `cfg_icw3` and then goes to the fourth word if `cfg_icw1` bit 0 is 1, else to ready. A data write in the fourth-word state loads `cfg_icw4` and always goes to ready.
- R5: A data write while ready, or while waiting for the first setup word, loads `imr`. Data writes taken as setup words leave `imr` unchanged. A read of the data location always returns `imr`.
- R6: While ready, a command write with bits 4:3 = 01 sets the status selector from bits 1:0. A command-location read then returns `irr_in` for 10, `isr_in` for 11 and 0x00 for any other value.
- R7: While ready, a command write with bits 4:3 = 00 and bits 7:5 = 011 is a specific end-of-interrupt. In the next cycle `isr_clr` carries a single bit at the position given by bits 2:0, for that one cycle only.
- R8: While ready, a command write with bits 4:3 = 00 and bits 7:5 = 001 is a non-specific end-of-interrupt. In the next cycle `isr_clr` carries only the lowest set bit of `isr_in` sampled at the write, or 0x00 if `isr_in` is zero.
- R9: While ready, command bytes with bits 4:3 = 00 and bits 7:5 = 110 (set priority) or 010 (no-op) produce no `isr_clr`, no `cmd_err` and no state change.
- R10: `cmd_err` pulses for one cycle after two kinds of command write. The first is a write with bits 4:3 = 00 whose bits 7:5 are none of 011, 001, 110 and 010, made while ready. The second is a write with bit 4 clear, made while not ready. Neither write changes any held state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| addr | input | 1 | 0 = command location, 1 = data location |
| wr_data | input | 8 | Write byte |
| irr_in | input | 8 | Request byte from the status block |
| isr_in | input | 8 | In-service byte from the status block |
| rd_data | output | 8 | Read byte for the location on `addr` (combinational) |
| imr | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base (second setup word) |
| cfg_icw1 | output | 8 | Stored first setup word |
| cfg_icw3 | output | 8 | Stored third setup word |
| cfg_icw4 | output | 8 | Stored fourth setup word |
| rd_sel | output | 2 | Status selector for command-location reads |
| ready | output | 1 | Setup sequence complete |
| isr_clr | output | 8 | One-cycle in-service clear mask |
| cmd_err | output | 1 | One-cycle invalid-command pulse |

## Verification
The properties assume that `wr_en` is low while reset is held. They also assume that `isr_in` is stable in the cycle of an end-of-interrupt write, since the clear mask is compared against the sampled byte one cycle later. The stimulus drives every input at the falling edge and deasserts `wr_en` before releasing reset. It holds `irr_in` and `isr_in` at fixed distinct patterns, so that each read selection and each non-specific clear has one unambiguous expected value.

// File: rtl/pic_cmd_if.sv
module pic_cmd_if (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] irr_in,
  input  logic [7:0] isr_in,
  output logic [7:0] rd_data,
  output logic [7:0] imr,
  output logic [7:0] vec_base,
  output logic [7:0] cfg_icw1,
  output logic [7:0] cfg_icw3,
  output logic [7:0] cfg_icw4,
  output logic [1:0] rd_sel,
  output logic       ready,
  output logic [7:0] isr_clr,
  output logic       cmd_err
);
  typedef enum logic [2:0] {W_ICW1, W_ICW2, W_ICW3, W_ICW4, RDY} seq_t;
  seq_t st;

  wire cmd_wr   = wr_en & ~addr;
  wire dat_wr   = wr_en & addr;
  wire is_init  = wr_data[4];
  wire is_op2   = wr_data[4:3] == 2'b00;
  wire [2:0] op = wr_data[7:5];
  wire [7:0] low_isr = isr_in & (~isr_in + 8'd1);

  assign ready   = st == RDY;
  assign rd_data = addr ? imr :
                   (rd_sel == 2'b10) ? irr_in :
                   (rd_sel == 2'b11) ? isr_in : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= W_ICW1;
      imr      <= '0;
      vec_base <= '0;
      cfg_icw1 <= '0;
      cfg_icw3 <= '0;
      cfg_icw4 <= '0;
      rd_sel   <= 2'b10;
      isr_clr  <= '0;
      cmd_err  <= 1'b0;
    end else begin
      isr_clr <= '0;
      cmd_err <= 1'b0;
      if (cmd_wr) begin
        if (is_init) begin
          cfg_icw1 <= wr_data;
          st       <= W_ICW2;
        end else if (st == RDY) begin
          if (is_op2) begin
            case (op)
              3'b011:          isr_clr <= 8'd1 << wr_data[2:0];
              3'b001:          isr_clr <= low_isr;
              3'b110, 3'b010:  ;
              default:         cmd_err <= 1'b1;
            endcase
          end else begin
            rd_sel <= wr_data[1:0];
          end
        end else begin
          cmd_err <= 1'b1;
        end
      end
      if (dat_wr) begin
        case (st)
          W_ICW2: begin
            vec_base <= wr_data;
            st <= !cfg_icw1[1] ? W_ICW3 : (cfg_icw1[0] ? W_ICW4 : RDY);
          end
          W_ICW3: begin
            cfg_icw3 <= wr_data;
            st <= cfg_icw1[0] ? W_ICW4 : RDY;
          end
          W_ICW4: begin
            cfg_icw4 <= wr_data;
            st <= RDY;
          end
          default: imr <= wr_data;
        endcase
      end
    end
  end
endmodule

module pic_cmd_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wr_data,
  input logic [7:0] isr_in,
  input logic [7:0] imr,
  input logic [7:0] isr_clr,
  input logic       cmd_err,
  input logic       ready
);
  a_r2_init_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wr_data[4]) |=> !ready);

  a_r5_imr_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr && ready) |-> imr == $past(wr_data));

  a_r7_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_clr != 8'h00) |-> $past(wr_en && !addr && ready && wr_data[4:3] == 2'b00
                                 && wr_data[5] && !wr_data[7]));

  a_r7_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr));

  a_r8_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !addr && ready && wr_data[7:3] == 5'b00100)
      |-> isr_clr == ($past(isr_in) & (~$past(isr_in) + 8'd1)));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !addr && ready && wr_data[4:3] == 2'b00 && !wr_data[5] && wr_data[6])
      |-> (isr_clr == 8'h00 && !cmd_err && ready));

  a_r10_err_no_clr: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> isr_clr == 8'h00);
endmodule

bind pic_cmd_if pic_cmd_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .isr_in(isr_in), .imr(imr), .isr_clr(isr_clr), .cmd_err(cmd_err), .ready(ready)
);

// File: tb/sim_pic_cmd_if.sv
module sim_pic_cmd_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] irr_in = 8'hA5;
  logic [7:0] isr_in = 8'h5C;
  logic [7:0] rd_data, imr, vec_base, cfg_icw1, cfg_icw3, cfg_icw4, isr_clr;
  logic [1:0] rd_sel;
  logic ready, cmd_err;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pic_cmd_if u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .irr_in(irr_in), .isr_in(isr_in), .rd_data(rd_data), .imr(imr),
    .vec_base(vec_base), .cfg_icw1(cfg_icw1), .cfg_icw3(cfg_icw3),
    .cfg_icw4(cfg_icw4), .rd_sel(rd_sel), .ready(ready),
    .isr_clr(isr_clr), .cmd_err(cmd_err)
  );

  // row: kind[25:24] (0 none,1 cmd write,2 data write), byte[23:16],
  // observed[15:12], requirement[11:8], expected[7:0]
  // observed: 1 imr,2 vec,3 icw3,4 icw4,5 ready,6 cmd read,7 clr,8 err,9 icw1,10 data read
  localparam int NV = 32;
  localparam logic [25:0] VEC [NV] = '{
    {2'd1, 8'h11, 4'd9,  4'd2,  8'h11},  // R2
    {2'd0, 8'h00, 4'd5,  4'd2,  8'h00},  // R2
    {2'd2, 8'h08, 4'd2,  4'd3,  8'h08},  // R3
    {2'd2, 8'h04, 4'd3,  4'd3,  8'h04},  // R3
    {2'd2, 8'h01, 4'd4,  4'd4,  8'h01},  // R4
    {2'd0, 8'h00, 4'd5,  4'd4,  8'h01},  // R4
    {2'd2, 8'hF0, 4'd1,  4'd5,  8'hF0},  // R5
    {2'd0, 8'h00, 4'd10, 4'd5,  8'hF0},  // R5
    {2'd1, 8'h0B, 4'd6,  4'd6,  8'h5C},  // R6
    {2'd1, 8'h0A, 4'd6,  4'd6,  8'hA5},  // R6
    {2'd1, 8'h08, 4'd6,  4'd6,  8'h00},  // R6
    {2'd1, 8'h63, 4'd7,  4'd7,  8'h08},  // R7
    {2'd0, 8'h00, 4'd7,  4'd7,  8'h00},  // R7
    {2'd1, 8'h20, 4'd7,  4'd8,  8'h04},  // R8
    {2'd1, 8'hC5, 4'd7,  4'd9,  8'h00},  // R9
    {2'd1, 8'h40, 4'd8,  4'd9,  8'h00},  // R9
    {2'd1, 8'hA0, 4'd8,  4'd10, 8'h01},  // R10
    {2'd1, 8'hE2, 4'd8,  4'd10, 8'h01},  // R10
    {2'd0, 8'h00, 4'd8,  4'd10, 8'h00},  // R10
    {2'd1, 8'h13, 4'd5,  4'd2,  8'h00},  // R2
    {2'd2, 8'h20, 4'd2,  4'd3,  8'h20},  // R3
    {2'd2, 8'h03, 4'd4,  4'd3,  8'h03},  // R3
    {2'd0, 8'h00, 4'd3,  4'd3,  8'h04},  // R3
    {2'd1, 8'h12, 4'd9,  4'd2,  8'h12},  // R2
    {2'd2, 8'h40, 4'd5,  4'd3,  8'h01},  // R3
    {2'd1, 8'h10, 4'd5,  4'd2,  8'h00},  // R2
    {2'd1, 8'h0B, 4'd8,  4'd10, 8'h01},  // R10
    {2'd2, 8'h50, 4'd2,  4'd3,  8'h50},  // R3
    {2'd2, 8'h02, 4'd3,  4'd4,  8'h02},  // R4
    {2'd0, 8'h00, 4'd1,  4'd5,  8'hF0},  // R5
    {2'd0, 8'h00, 4'd5,  4'd4,  8'h01},  // R4
    {2'd2, 8'h77, 4'd1,  4'd5,  8'h77}   // R5
  };

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] obs(input logic [3:0] w);
    case (w)
      4'd1: obs = imr;
      4'd2: obs = vec_base;
      4'd3: obs = cfg_icw3;
      4'd4: obs = cfg_icw4;
      4'd5: obs = {7'd0, ready};
      4'd7: obs = isr_clr;
      4'd8: obs = {7'd0, cmd_err};
      4'd9: obs = cfg_icw1;
      default: obs = rd_data;
    endcase
  endfunction

  task automatic reset_checks;
    addr = 1'b0; #0;
    chk(1, {7'd0, ready}, 8'h00);
    chk(1, imr, 8'h00);
    chk(1, vec_base, 8'h00);
    chk(1, cfg_icw1 | cfg_icw3 | cfg_icw4, 8'h00);
    chk(1, rd_data, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_checks();  // R1
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25:24] == 2'd1) wr(1'b0, VEC[i][23:16]);
      else if (VEC[i][25:24] == 2'd2) wr(1'b1, VEC[i][23:16]);
      else @(negedge clk);
      addr = (VEC[i][15:12] == 4'd10);
      #0;
      chk(int'(VEC[i][11:8]), obs(VEC[i][15:12]), VEC[i][7:0]);
    end
    // R8: empty in-service byte gives no clear
    isr_in = 8'h00;
    wr(1'b0, 8'h20);
    chk(8, isr_clr, 8'h00);
    isr_in = 8'h80;
    wr(1'b0, 8'h20);
    chk(8, isr_clr, 8'h80);
    // R7: level 0 and level 7
    wr(1'b0, 8'h60);
    chk(7, isr_clr, 8'h01);
    wr(1'b0, 8'h67);
    chk(7, isr_clr, 8'h80);
    // R1: mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    reset_checks();
    // R5: mask load while waiting for the first setup word
    wr(1'b1, 8'h3C);
    chk(5, imr, 8'h3C);
    // R10: operating command before setup is an error and changes nothing
    wr(1'b0, 8'h0B);
    chk(10, {7'd0, cmd_err}, 8'h01);
    addr = 1'b0; #0;
    chk(10, rd_data, 8'hA5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule